// File: doc/BRIEF.md
# 8-Point DCT/IDCT Shared Datapath

This block computes a one-dimensional 8-point transform on a vector of eight signed 16-bit words. For each vector the caller picks either the forward DCT or the inverse DCT. The two transforms run on one arithmetic datapath. The block splits each transform into an even half and an odd half, so that two 4x4 constant matrix-vector units do the work of an 8x8 multiply. Every constant product is built from shifts, additions and subtractions that follow a signed-digit recoding of seven fixed-point cosine constants. The block has no general multiplier.

A vector enters in one cycle as eight parallel words, together with a mode bit and a valid strobe. The result leaves three register stages later as eight parallel words with its own valid strobe. The pipeline accepts a new vector on every cycle, and the mode may differ from one vector to the next. A two-dimensional transform is built outside this block, by running rows and then columns through it with a transpose store between the passes.

Top module: `dct8_xform`

## Requirements
- R1: While `rst` is high and for one clock edge afterwards, `out_valid` is 0 and `out_data` is all zeros. `in_ready` is 0 while `rst` is high and 1 once `rst` is low.
- R2: A vector is accepted on a rising edge when `in_valid` and `in_ready` are both 1. Its result appears with `out_valid` = 1 right after the third rising edge, counting the accepting edge as the first, and stays for exactly one cycle. When `in_valid` is 0, `in_data` and `in_mode` are ignored and no output is produced.
- R3: With `in_mode` = 0 (forward), output word k is the rounded sum over n of C(k,n)·x(n), within ±2 LSB, where `in_data[n]` is x(n). C(k,n) = Q(m)/4096. For k = 0, Q = 1448. Otherwise, m = (2n+1)·k mod 32 is folded into 0..8 (if m > 16, m becomes 32−m; if m > 8, m becomes 16−m and the sign is negated). The magnitudes are Q(1) = 2008, Q(2) = 1892, Q(3) = 1702, Q(4) = 1448, Q(5) = 1136, Q(6) = 782, Q(7) = 398 and Q(8) = 0. An all-zero input gives an all-zero output.
- R4: With `in_mode` = 1 (inverse), output word n is the rounded sum over k of C(k,n)·X(k), within ±2 LSB, where `in_data[k]` is X(k) and C is the same table as in R3.
- R5: The mode is captured with each accepted vector. Forward and inverse vectors may alternate on consecutive cycles with no gap, and each result follows its own mode.
- R6: Rounding is half away from zero. A forward vector of eight words equal to 32 gives exactly 91 in word 0. Eight words equal to −32 give exactly −91 in word 0. All other words are 0 in both cases.
- R7: Results outside the 16-bit signed range saturate. A forward vector of eight words equal to 32767 gives 32767 in word 0. Eight words equal to −32768 give −32768 in word 0.
- R8: A forward vector with x(n) = x(7−n) for all n gives exactly 0 in output words 1, 3, 5 and 7.
- R9: An inverse vector whose only nonzero word is X(0) gives eight identical outputs, each equal to round(1448·X(0)/4096). For X(0) = 1000 each output is 354.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector strobe |
| in_mode | input | 1 | 0 = forward DCT, 1 = inverse DCT |
| in_data | input | 8x16 | Eight signed input words, word j at `in_data[j]` |
| in_ready | output | 1 | High when a vector can be accepted |
| out_valid | output | 1 | Result strobe |
| out_data | output | 8x16 | Eight signed result words, word j at `out_data[j]` |

## Verification
A wrong constant recoding or a wrong sign in one matrix row shows up only in the output words that depend on that row. It shows up on the first vector that exercises that row, three edges after acceptance. A mode bit that falls out of step with its data in the pipeline shows up when the modes alternate back to back: one result carries the other transform. A slip in the valid pipeline shows up as an `out_valid` mismatch on the next cycle that is compared. The bench therefore compares every cycle against a direct 8x8 floating-point sum, with exact checks on the rounding, saturation and symmetry corners.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

    // sample, butterfly and accumulator widths
    localparam int SAMP_W = 16;
    localparam int FRAC_W = 12;
    localparam int MID_W  = SAMP_W + 1;
    localparam int ACC_W  = MID_W + FRAC_W + 3;
    localparam int NPT    = 8;
    localparam int HALF_N = NPT / 2;
    localparam int SD_DIGITS = FRAC_W + 2;

    // cosine constants scaled by 2**FRAC_W
    localparam int K_A = 1448;
    localparam int K_B = 2008;
    localparam int K_C = 1892;
    localparam int K_D = 1702;
    localparam int K_E = 1136;
    localparam int K_F = 782;
    localparam int K_G = 398;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [MID_W-1:0]  mid_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic {XF_FWD = 1'b0, XF_INV = 1'b1} xf_mode_e;

    typedef struct packed {
        logic                 vld;
        xf_mode_e             mode;
        mid_t [HALF_N-1:0]    ev;
        mid_t [HALF_N-1:0]    od;
    } stg1_t;

    typedef struct packed {
        logic                 vld;
        xf_mode_e             mode;
        acc_t [HALF_N-1:0]    ev;
        acc_t [HALF_N-1:0]    od;
    } stg2_t;

    // constant product by signed-digit recoding: each nonzero digit adds or subtracts a shifted copy
    function automatic acc_t sd_scale(acc_t x, int k);
        acc_t r;
        int   rem;
        r   = '0;
        rem = k;
        for (int i = 0; i < SD_DIGITS; i++) begin
            if ((rem & 1) != 0) begin
                if ((rem & 3) == 3) begin
                    r   = r - (x <<< i);
                    rem = rem + 1;
                end else begin
                    r   = r + (x <<< i);
                    rem = rem - 1;
                end
            end
            rem = rem >>> 1;
        end
        return r;
    endfunction

    // drop FRAC_W fraction bits, ties away from zero, clamp to the sample range
    function automatic samp_t round_sat(acc_t v);
        acc_t half_lsb;
        acc_t mag;
        acc_t q;
        acc_t r;
        acc_t hi;
        acc_t lo;
        half_lsb = '0;
        half_lsb[FRAC_W-1] = 1'b1;
        hi  = acc_t'((1 <<< (SAMP_W-1)) - 1);
        lo  = -acc_t'(1 <<< (SAMP_W-1));
        mag = (v < 0) ? -v : v;
        q   = (mag + half_lsb) >>> FRAC_W;
        r   = (v < 0) ? -q : q;
        if (r > hi)      r = hi;
        else if (r < lo) r = lo;
        return samp_t'(r[SAMP_W-1:0]);
    endfunction

endpackage

// File: rtl/dct8_pre.sv
module dct8_pre
    import dct8_pkg::*;
(
    input  xf_mode_e           mode,
    input  samp_t [NPT-1:0]    x,
    output mid_t  [HALF_N-1:0] ev,
    output mid_t  [HALF_N-1:0] od
);

    always_comb begin
        ev = '0;
        od = '0;
        for (int i = 0; i < HALF_N; i++) begin
            if (mode == XF_INV) begin
                // inverse: split into even-index and odd-index coefficients
                ev[i] = mid_t'(x[2*i]);
                od[i] = mid_t'(x[2*i+1]);
            end else begin
                // forward: mirror-pair butterfly
                ev[i] = mid_t'(x[i]) + mid_t'(x[NPT-1-i]);
                od[i] = mid_t'(x[i]) - mid_t'(x[NPT-1-i]);
            end
        end
    end

endmodule

// File: rtl/dct8_even_mvm.sv
module dct8_even_mvm
    import dct8_pkg::*;
(
    input  xf_mode_e           mode,
    input  mid_t  [HALF_N-1:0] u,
    output acc_t  [HALF_N-1:0] r
);

    acc_t pa [HALF_N];
    acc_t pc [HALF_N];
    acc_t pf [HALF_N];

    for (genvar i = 0; i < HALF_N; i++) begin : g_prod
        assign pa[i] = sd_scale(acc_t'(u[i]), K_A);
        assign pc[i] = sd_scale(acc_t'(u[i]), K_C);
        assign pf[i] = sd_scale(acc_t'(u[i]), K_F);
    end

    // the even matrix is not symmetric: forward uses its rows, inverse its columns
    always_comb begin
        if (mode == XF_INV) begin
            r[0] = pa[0] + pc[1] + pa[2] + pf[3];
            r[1] = pa[0] + pf[1] - pa[2] - pc[3];
            r[2] = pa[0] - pf[1] - pa[2] + pc[3];
            r[3] = pa[0] - pc[1] + pa[2] - pf[3];
        end else begin
            r[0] = pa[0] + pa[1] + pa[2] + pa[3];
            r[1] = pc[0] + pf[1] - pf[2] - pc[3];
            r[2] = pa[0] - pa[1] - pa[2] + pa[3];
            r[3] = pf[0] - pc[1] + pc[2] - pf[3];
        end
    end

endmodule

// File: rtl/dct8_odd_mvm.sv
module dct8_odd_mvm
    import dct8_pkg::*;
(
    input  mid_t  [HALF_N-1:0] u,
    output acc_t  [HALF_N-1:0] r
);

    acc_t pb [HALF_N];
    acc_t pd [HALF_N];
    acc_t pe [HALF_N];
    acc_t pg [HALF_N];

    for (genvar i = 0; i < HALF_N; i++) begin : g_prod
        assign pb[i] = sd_scale(acc_t'(u[i]), K_B);
        assign pd[i] = sd_scale(acc_t'(u[i]), K_D);
        assign pe[i] = sd_scale(acc_t'(u[i]), K_E);
        assign pg[i] = sd_scale(acc_t'(u[i]), K_G);
    end

    // symmetric matrix: the same rows serve both directions
    always_comb begin
        r[0] = pb[0] + pd[1] + pe[2] + pg[3];
        r[1] = pd[0] - pg[1] - pb[2] - pe[3];
        r[2] = pe[0] - pb[1] + pg[2] + pd[3];
        r[3] = pg[0] - pe[1] + pd[2] - pb[3];
    end

endmodule

// File: rtl/dct8_post.sv
module dct8_post
    import dct8_pkg::*;
(
    input  xf_mode_e           mode,
    input  acc_t  [HALF_N-1:0] e,
    input  acc_t  [HALF_N-1:0] o,
    output samp_t [NPT-1:0]    y
);

    always_comb begin
        y = '0;
        for (int i = 0; i < HALF_N; i++) begin
            if (mode == XF_INV) begin
                y[i]       = round_sat(e[i] + o[i]);
                y[NPT-1-i] = round_sat(e[i] - o[i]);
            end else begin
                y[2*i]     = round_sat(e[i]);
                y[2*i+1]   = round_sat(o[i]);
            end
        end
    end

endmodule

// File: rtl/dct8_xform.sv
module dct8_xform
    import dct8_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    input  logic                           in_mode,
    input  logic [NPT-1:0][SAMP_W-1:0]     in_data,
    output logic                           in_ready,
    output logic                           out_valid,
    output logic [NPT-1:0][SAMP_W-1:0]     out_data
);

    logic              in_fire;
    mid_t [HALF_N-1:0] pre_ev;
    mid_t [HALF_N-1:0] pre_od;
    acc_t [HALF_N-1:0] mvm_ev;
    acc_t [HALF_N-1:0] mvm_od;
    samp_t [NPT-1:0]   post_y;

    stg1_t             s1_q;
    stg2_t             s2_q;
    logic              ov_q;
    samp_t [NPT-1:0]   y_q;

    assign in_ready = !rst;
    assign in_fire  = in_valid && in_ready;

    dct8_pre u_pre (
        .mode (xf_mode_e'(in_mode)),
        .x    (in_data),
        .ev   (pre_ev),
        .od   (pre_od)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld  <= in_fire;
            s1_q.mode <= xf_mode_e'(in_mode);
            s1_q.ev   <= pre_ev;
            s1_q.od   <= pre_od;
        end
    end

    dct8_even_mvm u_even (
        .mode (s1_q.mode),
        .u    (s1_q.ev),
        .r    (mvm_ev)
    );

    dct8_odd_mvm u_odd (
        .u    (s1_q.od),
        .r    (mvm_od)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q.vld  <= s1_q.vld;
            s2_q.mode <= s1_q.mode;
            s2_q.ev   <= mvm_ev;
            s2_q.od   <= mvm_od;
        end
    end

    AST_ODD_ZERO_PATH: assert property (@(posedge clk) disable iff (rst) (s1_q.vld && s1_q.od == '0) |=> (s2_q.od == '0)); // R8

    dct8_post u_post (
        .mode (s2_q.mode),
        .e    (s2_q.ev),
        .o    (s2_q.od),
        .y    (post_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q <= 1'b0;
            y_q  <= '0;
        end else begin
            ov_q <= s2_q.vld;
            y_q  <= post_y;
        end
    end

    assign out_valid = ov_q;
    assign out_data  = y_q;

    logic fwd_sym;
    logic inv_dc_only;
    assign fwd_sym = (in_data[0] == in_data[7]) && (in_data[1] == in_data[6])
                  && (in_data[2] == in_data[5]) && (in_data[3] == in_data[4]);
    assign inv_dc_only = (in_data[NPT-1:1] == '0);

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst) out_valid == $past(in_fire, 3)); // R2
    AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (rst) (in_fire && in_data == '0) |-> ##3 (out_valid && out_data == '0)); // R3
    AST_SYM_ODD_ZERO: assert property (@(posedge clk) disable iff (rst) (in_fire && !in_mode && fwd_sym) |-> ##3 (out_data[1] == '0 && out_data[3] == '0 && out_data[5] == '0 && out_data[7] == '0)); // R8
    AST_DC_FLAT: assert property (@(posedge clk) disable iff (rst) (in_fire && in_mode && inv_dc_only) |-> ##3 (out_data == {NPT{out_data[0]}})); // R9

endmodule

// File: tb/sim_dct8_xform.sv
module sim_dct8_xform;

    localparam int TOL      = 2;
    localparam int WD_LIMIT = 50000;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic             in_mode;
    logic [7:0][15:0] in_data;
    logic             in_ready;
    logic             out_valid;
    logic [7:0][15:0] out_data;

    always #4 clk = ~clk;

    dct8_xform u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    started = 0;
    bit    cur_exact;
    string cur_tag;

    int    mexp [3][8];
    bit    mv   [3];
    bit    mex  [3];
    string mtag [3];

    function automatic int coef_k(int k, int n);
        int m, s, mag;
        if (k == 0) return 1448;
        m = ((2*n+1)*k) % 32;
        if (m > 16) m = 32 - m;
        s = 1;
        if (m > 8) begin m = 16 - m; s = -1; end
        case (m)
            1: mag = 2008;
            2: mag = 1892;
            3: mag = 1702;
            4: mag = 1448;
            5: mag = 1136;
            6: mag = 782;
            7: mag = 398;
            default: mag = 0;
        endcase
        return s * mag;
    endfunction

    // direct 8x8 sum in floating point, rounded half away from zero and clamped
    function automatic int ref_out(bit inv, int j, logic [7:0][15:0] d);
        longint sum;
        real    v, r;
        sum = 0;
        for (int i = 0; i < 8; i++) begin
            if (!inv) sum += longint'(coef_k(j, i)) * longint'($signed(d[i]));
            else      sum += longint'(coef_k(i, j)) * longint'($signed(d[i]));
        end
        v = real'(sum) / 4096.0;
        r = (v >= 0.0) ? $floor(v + 0.5) : -$floor(-v + 0.5);
        if (r > 32767.0)  r = 32767.0;
        if (r < -32768.0) r = -32768.0;
        return $rtoi(r);
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // behavioural pipeline model: three slots, shifted on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < 3; s++) mv[s] = 1'b0;
        end else begin
            for (int s = 2; s > 0; s--) begin
                mv[s]   = mv[s-1];
                mex[s]  = mex[s-1];
                mtag[s] = mtag[s-1];
                for (int j = 0; j < 8; j++) mexp[s][j] = mexp[s-1][j];
            end
            mv[0] = in_valid && in_ready;
            if (mv[0]) begin
                mex[0]  = cur_exact;
                mtag[0] = cur_tag;
                for (int j = 0; j < 8; j++) mexp[0][j] = ref_out(in_mode, j, in_data);
            end
        end
    end

    always @(negedge clk) begin
        if (started && !rst) begin
            n_tests++;
            if (out_valid !== mv[2]) begin
                n_fail++;
                $display("FAIL R2 out_valid: actual %0b expected %0b", out_valid, mv[2]);
            end else if (mv[2]) begin
                bit bad;
                bad = 0;
                n_tests++;
                for (int j = 0; j < 8; j++) begin
                    int act, diff;
                    act  = int'($signed(out_data[j]));
                    diff = act - mexp[2][j];
                    if (!bad && ((mex[2] && diff != 0) || diff > TOL || diff < -TOL)) begin
                        bad = 1;
                        n_fail++;
                        $display("FAIL %s word %0d: actual %0d expected %0d", mtag[2], j, act, mexp[2][j]);
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual %0d cycles expected under %0d", cyc, WD_LIMIT);
            summary();
        end
    end

    function automatic logic [7:0][15:0] fill(int v);
        logic [7:0][15:0] d;
        for (int i = 0; i < 8; i++) d[i] = 16'(v);
        return d;
    endfunction

    function automatic logic [15:0] pick_word();
        int sel;
        sel = $urandom_range(0, 9);
        if (sel == 0) return 16'h7FFF;
        if (sel == 1) return 16'h8000;
        if (sel == 2) return 16'h0000;
        return 16'($urandom);
    endfunction

    task automatic send(bit m, logic [7:0][15:0] d, bit ex, string tag);
        in_valid  = 1'b1;
        in_mode   = m;
        in_data   = d;
        cur_exact = ex;
        cur_tag   = tag;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_data = {$urandom, $urandom, $urandom, $urandom};
            in_mode = 1'($urandom);
            @(negedge clk);
        end
    endtask

    initial begin
        logic [7:0][15:0] d;
        rst = 1'b1; in_valid = 1'b0; in_mode = 1'b0; in_data = '0;
        cur_exact = 1'b0; cur_tag = "R3";
        repeat (4) @(negedge clk);
        // R1 reset state
        n_tests++;
        if (out_valid !== 1'b0 || out_data !== '0 || in_ready !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: actual v=%0b d=%h rdy=%0b expected 0 0 0", out_valid, out_data, in_ready);
        end
        rst = 1'b0;
        started = 1'b1;
        @(negedge clk);
        n_tests++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 after reset: actual rdy=%0b v=%0b expected 1 0", in_ready, out_valid);
        end

        send(1'b0, fill(0), 1'b1, "R3");
        send(1'b0, fill(32), 1'b1, "R6");
        send(1'b0, fill(-32), 1'b1, "R6");
        send(1'b0, fill(32767), 1'b1, "R7");
        send(1'b0, fill(-32768), 1'b1, "R7");
        d = '0; d[0] = 16'd1000;
        send(1'b1, d, 1'b1, "R9");
        d = '0; d[0] = 16'h8000;
        send(1'b1, d, 1'b1, "R9");
        d[0] = 16'd100;  d[7] = 16'd100;
        d[1] = -16'sd200; d[6] = -16'sd200;
        d[2] = 16'd300;  d[5] = 16'd300;
        d[3] = -16'sd400; d[4] = -16'sd400;
        send(1'b0, d, 1'b1, "R8");
        idle(5);

        // R5 strict alternation, no gaps
        for (int k = 0; k < 200; k++) begin
            for (int i = 0; i < 8; i++) d[i] = pick_word();
            send(1'(k % 2), d, 1'b0, "R5");
        end
        idle(3);

        // R3/R4 random and extreme vectors with random gaps (R2)
        for (int k = 0; k < 300; k++) begin
            bit m;
            m = 1'($urandom);
            for (int i = 0; i < 8; i++) d[i] = pick_word();
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
            if (m) send(1'b1, d, 1'b0, "R4");
            else   send(1'b0, d, 1'b0, "R3");
        end
        idle(6);
        summary();
    end

endmodule